// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt requests from a parameterised set of sources and presents them to a single processor context. Each source has three state bits: a pending bit, a claimed bit and a shadow bit. The shadow bit records a level that arrives while the source is being serviced. Software programs a 3-bit priority for each source, an enable bit for each source and a 2-bit global threshold. When at least one pending and enabled source has a priority strictly above the threshold, the controller raises one interrupt line.

Software services an interrupt with a single register. A read returns the identifier of the best eligible source and marks that source as in service. A write of the same identifier ends the service. A level that was held up during service is replayed as pending at the moment service ends. The register port takes 32-bit words with separate read and write strobes and a word index (byte offset = 4 × index). Read data is registered and is valid in the cycle after the read strobe. When both strobes are high, the write is taken and the read is ignored.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, and the threshold, the claim register and every pending word read 0.
- R2: A high level on a source that is not in service sets its pending bit on the next clock. The bit stays set after the level falls until the source is claimed. Pending word k (byte offset 4·k) holds source 32·k+b in bit b.
- R3: Writes to the pending words are ignored.
- R4: The priority of source n (n ≥ 1) is at byte offset 0x030 + 4·(n−1) and keeps only bits [2:0]. The threshold at 0x318 keeps only bits [1:0].
- R5: A source is eligible only when it is pending, enabled and has a priority strictly greater than the threshold. The interrupt line is high exactly when some source is eligible.
- R6: Among eligible sources the highest priority wins. On equal priority the lowest identifier wins.
- R7: A read of the claim register (0x31C) returns the winner, clears its pending bit and marks it in service. The read returns 0 when no source is eligible.
- R8: While a source is in service, a high level sets only its shadow bit and never its pending bit. A low level clears the shadow bit.
- R9: Writing the identifier of an in-service source to 0x31C ends its service. If its shadow bit is set, the pending bit is set on that same clock edge.
- R10: A completion write with an identifier that is 0, is at or above the source count, or is not in service has no effect.
- R11: The mode window (0x018–0x02F) reads 0 and ignores writes. Enable words at 0x300 + 4·k are full 32-bit read/write registers, with source 32·k+b in bit b.
- R12: Source 0 never becomes pending and never wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Source request levels; bit n is source n |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Word index (byte offset divided by 4) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench focuses on service-time behaviour:
- A source is raised during service and then drops before completion. A design that forgot to clear the shadow bit would re-raise that source by mistake.
- A source is dropped on the same edge as its completion. A design that waited for the live level, instead of replaying the shadow bit at once, would lose the interrupt.
- A completion identifier is chosen to alias a claimed source in its low bits. A controller that truncates the identifier would end the wrong service.
- Two sources tie on priority, and the threshold is set equal to a priority. These catch arbitration that prefers the higher identifier and a threshold compare that is not strict.

// File: rtl/lvl_irq_pkg.sv
`timescale 1ns/1ps
package lvl_irq_pkg;
   // Word indices inside the 1 KiB window (byte offset / 4)
   localparam logic [7:0] PEND_WBASE  = 8'h00;
   localparam logic [7:0] MODE_WBASE  = 8'h06;
   localparam int         MODE_WORDS  = 6;
   localparam logic [7:0] PRIO_WBASE  = 8'h0C;
   localparam logic [7:0] EN_WBASE    = 8'hC0;
   localparam logic [7:0] THR_WADDR   = 8'hC6;
   localparam logic [7:0] CLAIM_WADDR = 8'hC7;
   localparam int         BUS_W       = 32;
endpackage

// File: rtl/lvl_irq_gateway.sv
`timescale 1ns/1ps
module lvl_irq_gateway (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   input  logic claim_i,
   input  logic complete_i,
   output logic pend_o,
   output logic shadow_o,
   output logic busy_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o   <= 1'b0;
         shadow_o <= 1'b0;
         busy_o   <= 1'b0;
      end else if (claim_i) begin
         pend_o   <= 1'b0;
         shadow_o <= 1'b0;
         busy_o   <= 1'b1;
      end else if (complete_i && busy_o) begin
         busy_o   <= 1'b0;
         pend_o   <= shadow_o;
         shadow_o <= 1'b0;
      end else if (busy_o) begin
         shadow_o <= level_i;
      end else if (level_i) begin
         pend_o   <= 1'b1;
      end
   end
endmodule

// File: rtl/lvl_irq_arbiter.sv
`timescale 1ns/1ps
module lvl_irq_arbiter #(
   parameter int NSRC   = 64,
   parameter int PRIO_W = 3,
   parameter int THR_W  = 2,
   localparam int IDW   = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]             pend_i,
   input  logic [NSRC-1:0]             en_i,
   input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [THR_W-1:0]            thr_i,
   output logic [IDW-1:0]              win_id_o,
   output logic                        win_valid_o
);
   logic [PRIO_W-1:0] best_p;

   always_comb begin
      win_id_o    = '0;
      best_p      = '0;
      win_valid_o = 1'b0;
      // Ascending scan with strict compare keeps the lowest id on ties
      for (int i = 1; i < NSRC; i++) begin
         if (pend_i[i] && en_i[i] && (prio_i[i] > PRIO_W'(thr_i)) &&
             (prio_i[i] > best_p)) begin
            best_p      = prio_i[i];
            win_id_o    = IDW'(i);
            win_valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lvl_irq_ctrl.sv
`timescale 1ns/1ps
module lvl_irq_ctrl
   import lvl_irq_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int PRIO_W = 3,
   parameter int THR_W  = 2,
   localparam int IDW   = $clog2(NSRC),
   localparam int ENW   = NSRC / 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NSRC-1:0]  src_i,
   input  logic             bus_we_i,
   input  logic             bus_re_i,
   input  logic [7:0]       bus_addr_i,
   input  logic [BUS_W-1:0] bus_wdata_i,
   output logic [BUS_W-1:0] bus_rdata_o,
   output logic             irq_o
);
   // Elaboration checks: pending words must fit before the mode window,
   // priority words before the enable window.
   if ((NSRC % 32) != 0 || NSRC < 32 || NSRC > 160) begin : g_bad_nsrc
      $error("NSRC must be a multiple of 32 between 32 and 160");
   end
   if (PRIO_W < THR_W || PRIO_W > 8) begin : g_bad_width
      $error("PRIO_W must be at least THR_W and at most 8");
   end

   logic [NSRC-1:0]             pend_vec, shadow_vec, busy_vec;
   logic [NSRC-1:0]             claim_vec, cmpl_vec, en_vec;
   logic [NSRC-1:0][PRIO_W-1:0] prio_q;
   logic [ENW-1:0][31:0]        en_q;
   logic [THR_W-1:0]            thr_q;
   logic [IDW-1:0]              win_id;
   logic                        win_valid;
   logic [BUS_W-1:0]            rd_next;
   logic                        rd_claim, wr_cmpl;

   assign rd_claim = bus_re_i && !bus_we_i && (bus_addr_i == CLAIM_WADDR);
   assign wr_cmpl  = bus_we_i && (bus_addr_i == CLAIM_WADDR);
   assign en_vec   = en_q;

   // Per-source gateways; source 0 is reserved
   assign pend_vec[0]   = 1'b0;
   assign shadow_vec[0] = 1'b0;
   assign busy_vec[0]   = 1'b0;
   assign claim_vec[0]  = 1'b0;
   assign cmpl_vec[0]   = 1'b0;
   for (genvar g = 1; g < NSRC; g++) begin : g_src
      assign claim_vec[g] = rd_claim && win_valid && (win_id == IDW'(g));
      assign cmpl_vec[g]  = wr_cmpl && (bus_wdata_i == BUS_W'(g));
      lvl_irq_gateway u_gw (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .level_i    (src_i[g]),
         .claim_i    (claim_vec[g]),
         .complete_i (cmpl_vec[g]),
         .pend_o     (pend_vec[g]),
         .shadow_o   (shadow_vec[g]),
         .busy_o     (busy_vec[g])
      );
   end

   lvl_irq_arbiter #(
      .NSRC   (NSRC),
      .PRIO_W (PRIO_W),
      .THR_W  (THR_W)
   ) u_arb (
      .pend_i      (pend_vec),
      .en_i        (en_vec),
      .prio_i      (prio_q),
      .thr_i       (thr_q),
      .win_id_o    (win_id),
      .win_valid_o (win_valid)
   );

   assign irq_o = win_valid;

   // Configuration registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prio_q <= '0;
         en_q   <= '0;
         thr_q  <= '0;
      end else if (bus_we_i) begin
         for (int i = 1; i < NSRC; i++) begin
            if (bus_addr_i == 8'(int'(PRIO_WBASE) + i - 1))
               prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
         end
         for (int k = 0; k < ENW; k++) begin
            if (bus_addr_i == 8'(int'(EN_WBASE) + k))
               en_q[k] <= bus_wdata_i;
         end
         if (bus_addr_i == THR_WADDR)
            thr_q <= bus_wdata_i[THR_W-1:0];
      end
   end

   // Read mux; mode window and unmapped words fall through to zero
   always_comb begin
      rd_next = '0;
      for (int k = 0; k < ENW; k++) begin
         if (bus_addr_i == 8'(int'(PEND_WBASE) + k))
            rd_next = pend_vec[32*k +: 32];
         if (bus_addr_i == 8'(int'(EN_WBASE) + k))
            rd_next = en_q[k];
      end
      for (int i = 1; i < NSRC; i++) begin
         if (bus_addr_i == 8'(int'(PRIO_WBASE) + i - 1))
            rd_next = BUS_W'(prio_q[i]);
      end
      if (bus_addr_i == THR_WADDR)
         rd_next = BUS_W'(thr_q);
      if (bus_addr_i == CLAIM_WADDR)
         rd_next = win_valid ? BUS_W'(win_id) : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         bus_rdata_o <= '0;
      else if (bus_re_i && !bus_we_i)
         bus_rdata_o <= rd_next;
   end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_chk #(
   parameter int NSRC  = 64,
   parameter int THR_W = 2,
   parameter int IDW   = 6
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [NSRC-1:0]  src_i,
   input logic             bus_we_i,
   input logic             bus_re_i,
   input logic [7:0]       bus_addr_i,
   input logic [31:0]      bus_wdata_i,
   input logic             irq_o,
   input logic [NSRC-1:0]  pend_vec,
   input logic [NSRC-1:0]  shadow_vec,
   input logic [NSRC-1:0]  busy_vec,
   input logic [NSRC-1:0]  en_vec,
   input logic [THR_W-1:0] thr_q,
   input logic [IDW-1:0]   win_id
);
   // R8
   shadow_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shadow_vec & ~busy_vec) == '0);

   // R7
   pend_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_vec & busy_vec) == '0);

   // R7
   claim_marks_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_re_i && !bus_we_i && bus_addr_i == 8'hC7 && irq_o)
      |=> busy_vec[$past(win_id)] && !pend_vec[$past(win_id)]);

   // R4
   thr_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == 8'hC6) |=> thr_q == $past(bus_wdata_i[THR_W-1:0]));

   // R2
   pend_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_vec & ~$past(pend_vec) & ~$past(src_i | shadow_vec)) == '0);

   // R5
   irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (pend_vec & en_vec) != '0);
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(
   .NSRC  (NSRC),
   .THR_W (THR_W),
   .IDW   (IDW)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .src_i       (src_i),
   .bus_we_i    (bus_we_i),
   .bus_re_i    (bus_re_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_o       (irq_o),
   .pend_vec    (pend_vec),
   .shadow_vec  (shadow_vec),
   .busy_vec    (busy_vec),
   .en_vec      (en_vec),
   .thr_q       (thr_q),
   .win_id      (win_id)
);

// File: tb/lvl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_bench;
   localparam int NSRC = 64;
   localparam logic [7:0] A_PEND0 = 8'h00, A_PEND1 = 8'h01, A_MODE = 8'h06;
   localparam logic [7:0] A_EN0 = 8'hC0, A_EN1 = 8'hC1, A_THR = 8'hC6, A_CLM = 8'hC7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src = '0;
   logic            we = 1'b0, re = 1'b0;
   logic [7:0]      addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic            irq;
   logic            rd_seen = 1'b0;
   logic            done = 1'b0;
   int              checks = 0, failures = 0;
   logic [31:0]     exp_q[$];
   string           tag_q[$];

   always #10 clk = ~clk;

   lvl_irq_ctrl #(.NSRC(NSRC)) u_lvl_irq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we), .bus_re_i(re),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [7:0] a_prio(int id);
      return 8'(12 + id - 1);
   endfunction

   // Monitor: read data is due one edge after the strobe
   always @(posedge clk) rd_seen <= re;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rdata !== e) begin
            failures++;
            $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
         end
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] e, string t);
      exp_q.push_back(e); tag_q.push_back(t);
      re = 1'b1; addr = a;
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(logic e, string t);
      checks++;
      if (irq !== e) begin
         failures++;
         $display("FAIL %s: irq=%b expected=%b", t, irq, e);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: finished=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      rd(A_THR, 0, "R1 threshold");
      rd(A_CLM, 0, "R1 claim");
      rd(A_PEND0, 0, "R1 pend0");
      rd(A_PEND1, 0, "R1 pend1");
      // R11 mode window and enable words
      wr(A_MODE, 32'hFFFF_FFFF);
      rd(A_MODE, 0, "R11 mode window");
      wr(A_EN1, 32'hA5A5_0F0F);
      rd(A_EN1, 32'hA5A5_0F0F, "R11 enable word");
      wr(A_EN1, 0);
      // R4 truncation
      wr(a_prio(5), 32'hFF);
      rd(a_prio(5), 7, "R4 priority bits");
      wr(A_THR, 32'hFF);
      rd(A_THR, 3, "R4 threshold bits");
      wr(A_THR, 0);
      // R2 sticky pending
      src[5] = 1'b1; idle(1); src[5] = 1'b0; idle(1);
      rd(A_PEND0, 32'h20, "R2 sticky pending");
      chk_irq(1'b0, "R5 disabled source");
      // R3 read-only pending
      wr(A_PEND0, 0);
      rd(A_PEND0, 32'h20, "R3 pending write ignored");
      // R5 eligibility
      wr(A_EN0, 32'h20);
      chk_irq(1'b1, "R5 enabled source");
      wr(a_prio(5), 2); wr(A_THR, 2);
      chk_irq(1'b0, "R5 priority equal threshold");
      wr(A_THR, 1);
      chk_irq(1'b1, "R5 priority above threshold");
      // R6 arbitration
      wr(a_prio(9), 3); wr(a_prio(40), 3);
      wr(A_EN0, 32'h220); wr(A_EN1, 32'h100);
      src[9] = 1'b1; src[40] = 1'b1; idle(1);
      src[9] = 1'b0; src[40] = 1'b0; idle(1);
      rd(A_CLM, 9, "R6 tie lowest id");
      rd(A_PEND0, 32'h20, "R7 claim clears pending");
      rd(A_PEND1, 32'h100, "R7 other pending kept");
      rd(A_CLM, 40, "R6 next priority");
      rd(A_CLM, 5, "R6 lower priority last");
      rd(A_CLM, 0, "R7 none eligible");
      chk_irq(1'b0, "R7 irq low when all claimed");
      // R8 shadow bit while in service
      src[9] = 1'b1; src[40] = 1'b1; idle(2);
      rd(A_PEND0, 0, "R8 no pending while claimed");
      rd(A_PEND1, 0, "R8 no pending while claimed hi");
      src[9] = 1'b0; idle(2);
      wr(A_CLM, 9);
      rd(A_PEND0, 0, "R8 low level cleared shadow");
      // R9 replay on completion
      src[40] = 1'b0;
      wr(A_CLM, 40);
      rd(A_PEND1, 32'h100, "R9 shadow replayed at completion");
      chk_irq(1'b1, "R9 irq after replay");
      // R10 ignored completions
      src[5] = 1'b1; idle(2);
      wr(A_CLM, 69); wr(A_CLM, 9); wr(A_CLM, 0);
      rd(A_PEND0, 0, "R10 bad ids ignored");
      rd(A_CLM, 40, "R10 claim still works");
      wr(A_CLM, 5);
      rd(A_PEND0, 32'h20, "R9 completion re-pends");
      // R12 source zero
      src[0] = 1'b1; idle(2);
      rd(A_PEND0, 32'h20, "R12 source zero never pends");
      rd(A_CLM, 5, "R12 source zero never wins");
      src = '0; idle(2);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule